// File: doc/BRIEF.md
# GPIO Level Alarm Detector

The block watches a synchronised input port against two programmable masks, one for bits that should raise an alarm when they read 1 and one for bits that should raise an alarm when they read 0. Its registered alarm output stays high for as long as any watched bit is in its alarm state. Commands arrive on a small valid/ready stream that sets bits in either mask, removes bits from both masks, or arms the interrupt enables.

The low IRQ_W bits of the port also have per-bit interrupt enables. An arm command enables only those bits that currently read 0 and have a high alarm set. When an enabled bit then reads 1, the block emits a single-cycle interrupt pulse and clears that bit's enable by itself. A periodic tick input samples the full alarm condition into a wake pulse. This covers bits that have no interrupt support.

The command stream never applies back-pressure: `cmd_ready_o` is held high, and every cycle with `cmd_valid_i` high consumes one command.

Top module: `lvl_alarm_top`

## Requirements
- R1: After reset both masks and the interrupt enables are zero, and `alarm_o`, `any_o`, `wake_o` and `irq_o` are all low.
- R2: Command op 1 ORs the argument into the high mask. `alarm_o` goes high while any pin selected by the high mask reads 1.
- R3: Command op 2 ORs the argument into the low mask. `alarm_o` goes high while any pin selected by the low mask reads 0.
- R4: Command op 3 removes the argument bits from both the high mask and the low mask.
- R5: `any_o` is 1 exactly when at least one bit of either mask is set.
- R6: Command op 4 ORs (NOT pins AND high mask) into the interrupt enables. Only the low IRQ_W pins take part.
- R7: When an enabled bit reads 1, `irq_o` pulses for exactly one cycle and that bit's enable is cleared. An enable that stays clear produces no further pulse.
- R8: A `tick_i` pulse produces a one-cycle `wake_o` pulse on the next cycle if, and only if, the alarm condition holds at that time.
- R9: Each pin passes through two synchroniser flops. A pin change applied before a rising edge appears on `alarm_o` after the third rising edge. A command changes `alarm_o` after the second rising edge.
- R10: `cmd_ready_o` is always 1. A cycle with `cmd_valid_i` low, or with op 0, 5, 6 or 7, changes neither mask nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | PORT_W | Asynchronous input pins |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready, always 1 |
| cmd_op_i | input | 3 | Command code: 1 set high, 2 set low, 3 clear, 4 arm |
| cmd_arg_i | input | PORT_W | Command bit argument |
| tick_i | input | 1 | Periodic re-evaluation tick |
| alarm_o | output | 1 | Registered alarm level |
| any_o | output | 1 | Some mask bit is set |
| wake_o | output | 1 | Tick-sampled alarm pulse |
| irq_o | output | 1 | Single-cycle interrupt pulse |
| irq_en_o | output | IRQ_W | Current interrupt enables |

## Verification
The assertions assume that `tick_i` is a pulse sampled on rising edges. They also assume that pins settle for at least a few cycles, so the synchronised value seen by an arm command is the one the stimulus intends. The bench changes pins only at falling edges and then waits four cycles before it issues a command or a tick. It never changes pins in the same cycle as a command. Because of this, arming and firing never compete for one bit, and every expected value follows from the settled pin pattern.

// File: rtl/lva_pkg.sv
package lva_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SET_HI = 3'd1,
    OP_SET_LO = 3'd2,
    OP_CLEAR  = 3'd3,
    OP_ARM    = 3'd4
  } lva_op_e;
endpackage

// File: rtl/lva_sync.sv
module lva_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lva_masks.sv
module lva_masks
  import lva_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_take,
  input  lva_op_e          cmd_op,
  input  logic [WIDTH-1:0] cmd_arg,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] hi_mask,
  output logic             cond,
  output logic             any
);
  logic [WIDTH-1:0] hi_q, lo_q;
  logic [WIDTH-1:0] hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (cmd_take) begin
      unique case (cmd_op)
        OP_SET_HI: hi_d = hi_q | cmd_arg;
        OP_SET_LO: lo_d = lo_q | cmd_arg;
        OP_CLEAR: begin
          hi_d = hi_q & ~cmd_arg;
          lo_d = lo_q & ~cmd_arg;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  logic hit_high, hit_low;
  assign hit_high = |(data & hi_q);
  assign hit_low  = |(~data & lo_q);
  assign cond     = hit_high | hit_low;
  assign any      = |(hi_q | lo_q);
  assign hi_mask  = hi_q;
endmodule

// File: rtl/lva_arm.sv
module lva_arm #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic [IRQ_W-1:0] data,
  input  logic [IRQ_W-1:0] hi_mask,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] en_q, pend, arm_bits, en_d;
  logic             irq_q;

  assign pend     = data & en_q;
  assign arm_bits = arm_req ? (~data & hi_mask) : '0;
  assign en_d     = (en_q & ~pend) | arm_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= |pend;
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/lvl_alarm_top.sv
module lvl_alarm_top
  import lva_pkg::*;
#(
  parameter int PORT_W      = 32,
  parameter int IRQ_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [PORT_W-1:0] cmd_arg_i,
  input  logic              tick_i,
  output logic              alarm_o,
  output logic              any_o,
  output logic              wake_o,
  output logic              irq_o,
  output logic [IRQ_W-1:0]  irq_en_o
);
  logic [PORT_W-1:0] sync_data;
  logic [PORT_W-1:0] hi_mask;
  logic              cond, cmd_take, arm_req;
  lva_op_e           op;

  assign cmd_ready_o = 1'b1;
  assign cmd_take    = cmd_valid_i & cmd_ready_o;
  assign op          = lva_op_e'(cmd_op_i);
  assign arm_req     = cmd_take && (op == OP_ARM);

  lva_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(sync_data)
  );

  lva_masks #(.WIDTH(PORT_W)) masks_i (
    .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .cmd_op(op),
    .cmd_arg(cmd_arg_i), .data(sync_data), .hi_mask(hi_mask),
    .cond(cond), .any(any_o)
  );

  lva_arm #(.IRQ_W(IRQ_W)) arm_i (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req),
    .data(sync_data[IRQ_W-1:0]), .hi_mask(hi_mask[IRQ_W-1:0]),
    .en_o(irq_en_o), .irq_o(irq_o)
  );

  logic alarm_q, wake_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      alarm_q <= cond;
      wake_q  <= tick_i & cond;
    end
  end

  assign alarm_o = alarm_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/lva_chk.sv
module lva_chk #(
  parameter int PORT_W = 32,
  parameter int IRQ_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [PORT_W-1:0] cmd_arg_i,
  input logic [PORT_W-1:0] sdata,
  input logic [IRQ_W-1:0]  en,
  input logic              any,
  input logic              alarm,
  input logic              wake,
  input logic              irq
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sdata[IRQ_W-1:0] & en)) |=> ((en & $past(sdata[IRQ_W-1:0] & en)) == '0)); // R7
  AST_ARM_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & ~$past(en) & $past(sdata[IRQ_W-1:0])) == '0)); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd3 && (&cmd_arg_i)) |=> !any); // R4
  AST_SET_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2) && (|cmd_arg_i)) |=> any); // R5
  AST_ALARM_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> $past(any)); // R5
  AST_WAKE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(tick_i)); // R8
endmodule

bind lvl_alarm_top lva_chk #(.PORT_W(PORT_W), .IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i), .sdata(sync_data),
  .en(irq_en_o), .any(any_o), .alarm(alarm_o), .wake(wake_o), .irq(irq_o)
);

// File: tb/lvl_alarm_top_tb_top.sv
module lvl_alarm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 32;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] pin_i = '0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [2:0]    cmd_op_i = 3'd0;
  logic [PW-1:0] cmd_arg_i = '0;
  logic          tick_i = 1'b0;
  logic          alarm_o, any_o, wake_o, irq_o;
  logic [IW-1:0] irq_en_o;

  int checks = 0, errors = 0;
  int irq_cnt = 0, wake_cnt = 0, irq_exp = 0, wake_exp = 0;
  logic [PW-1:0] m_hi = '0, m_lo = '0, m_pins = '0;
  logic [IW-1:0] m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_alarm_top #(.PORT_W(PW), .IRQ_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i),
    .tick_i(tick_i), .alarm_o(alarm_o), .any_o(any_o), .wake_o(wake_o),
    .irq_o(irq_o), .irq_en_o(irq_en_o)
  );

  always @(posedge clk) begin
    if (rst_n && irq_o) irq_cnt++;
    if (rst_n && wake_o) wake_cnt++;
  end

  function automatic logic exp_alarm(logic [PW-1:0] p, logic [PW-1:0] h, logic [PW-1:0] l);
    return (|(p & h)) || (|(~p & l));
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [PW-1:0] p);
    @(negedge clk);
    pin_i = p;
    if ((m_en & p[IW-1:0]) != '0) irq_exp++;
    m_en = m_en & ~p[IW-1:0];
    m_pins = p;
    wait_neg(4);
  endtask

  task automatic send(input logic v, input logic [2:0] op, input logic [PW-1:0] arg);
    @(negedge clk);
    cmd_valid_i = v; cmd_op_i = op; cmd_arg_i = arg;
    if (v) begin
      case (op)
        3'd1: m_hi = m_hi | arg;
        3'd2: m_lo = m_lo | arg;
        3'd3: begin m_hi = m_hi & ~arg; m_lo = m_lo & ~arg; end
        3'd4: m_en = m_en | (~m_pins[IW-1:0] & m_hi[IW-1:0]);
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0; cmd_arg_i = '0;
    wait_neg(2);
  endtask

  task automatic tick;
    @(negedge clk);
    tick_i = 1'b1;
    if (exp_alarm(m_pins, m_hi, m_lo)) wake_exp++;
    @(negedge clk);
    tick_i = 1'b0;
    wait_neg(2);
  endtask

  task automatic check_state(input string tag);
    chk(alarm_o == exp_alarm(m_pins, m_hi, m_lo), {tag, " R2 R3 alarm"}, alarm_o, exp_alarm(m_pins, m_hi, m_lo));
    chk(any_o == |(m_hi | m_lo), {tag, " R5 any"}, any_o, |(m_hi | m_lo));
    chk(irq_en_o == m_en, {tag, " R6 enables"}, irq_en_o, m_en);
    chk(irq_cnt == irq_exp, {tag, " R7 irq count"}, irq_cnt, irq_exp);
    chk(wake_cnt == wake_exp, {tag, " R8 wake count"}, wake_cnt, wake_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    // R1 reset state
    chk(!alarm_o && !any_o && !wake_o && !irq_o && irq_en_o == '0, "R1 reset", {alarm_o, any_o, wake_o, irq_o}, 0);
    chk(cmd_ready_o == 1'b1, "R10 ready", cmd_ready_o, 1);

    // R10 invalid cycles and unused ops leave state alone
    send(1'b0, 3'd1, '1);
    chk(!any_o, "R10 valid low", any_o, 0);
    send(1'b1, 3'd6, '1);
    send(1'b1, 3'd0, '1);
    chk(!any_o, "R10 unused op", any_o, 0);

    // R3 low alarm on bit 20 with pins low
    send(1'b1, 3'd2, 32'h0010_0000);
    check_state("low alarm");
    chk(alarm_o == 1'b1, "R3 low pin alarm", alarm_o, 1);

    // R9 latency of a pin change
    @(negedge clk);
    pin_i = 32'h0010_0000; m_pins = pin_i;
    @(negedge clk);
    @(negedge clk);
    chk(alarm_o == 1'b1, "R9 two edges old", alarm_o, 1);
    @(negedge clk);
    chk(alarm_o == 1'b0, "R9 third edge new", alarm_o, 0);
    wait_neg(2);

    // R2 high alarm, R6 arm, R7 fire once
    send(1'b1, 3'd1, 32'h0000_0005);
    send(1'b1, 3'd4, '0);
    chk(irq_en_o == 8'h05, "R6 arm low pins", irq_en_o, 8'h05);
    set_pins(32'h0010_0001);
    check_state("fire bit0");
    chk(irq_en_o == 8'h04, "R7 disarm fired", irq_en_o, 8'h04);
    set_pins(32'h0010_0000);
    set_pins(32'h0010_0001);
    chk(irq_cnt == 1, "R7 no refire", irq_cnt, 1);
    tick();
    check_state("tick hit");

    // R4 clear all
    send(1'b1, 3'd3, '1);
    check_state("clear all");
    chk(!any_o && !alarm_o, "R4 clear", {any_o, alarm_o}, 0);
    tick();
    chk(wake_cnt == wake_exp, "R8 no wake", wake_cnt, wake_exp);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0] op;
      logic [PW-1:0] arg;
      if ($urandom % 3 == 0) set_pins($urandom);
      op = 3'($urandom % 8);
      arg = (op == 3'd3) ? $urandom : ($urandom & $urandom & $urandom);
      send(($urandom % 8) != 0, op, arg);
      if ($urandom % 4 == 0) tick();
      check_state($sformatf("rand %0d", it));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule